// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Unit

This block watches a set of general-purpose input pins and raises an interrupt request whenever a selected pin changes level, in either direction. The pins fall into three groups. Each group has its own pin mask, its own enable bit and one pending flag that all of its pins share. A request leaves the block for each group. An encoded output gives the most urgent pending group. Each pin input is synchronized to the clock before any change on it is detected.

Software sets the masks and the group enables through a small register port. It reads or clears the pending flags through the same port. A per-group acknowledge input lets an interrupt controller clear a flag once it has taken the request. A global enable input gates all three requests without touching the flags.

Pin indices run 0 to 23. Group 0 holds pins 7..0, group 1 holds pins 14..8 and group 2 holds pins 23..16. Index 15 has no pin.

Top module: `pin_toggle_irq`

## Requirements
- R1: After reset all masks, group enables and flags read zero, and no request is active.
- R2: The register port uses these addresses. Address 0 is the group 0 mask, with data bit i for pin i. Address 1 is the group 1 mask, with data bit i for pin 8+i. Address 2 is the group 2 mask, with data bit i for pin 16+i. Address 3 holds the group enables in bits 2..0, bit g for group g. Address 4 holds the flags in bits 2..0. Any other address reads zero. Reads are combinational from `rd_addr_i`, and writes take effect at the clock edge where `wr_en_i` is high.
- R3: Mask bit 7 at address 1, which stands for the absent pin 15, always reads zero and ignores writes. A change on input 15 never sets a flag.
- R4: A rising or a falling change on a masked pin sets its group flag at the third rising clock edge after the input changes. The flag is still clear after the second edge.
- R5: A change on a pin whose mask bit is zero has no effect on any flag.
- R6: A group flag is set only if the group's enable bit is one while the change is being detected. Turning the enable on later does not bring back a missed change.
- R7: `irq_o[g]` is high exactly when flag g, enable g and `gie_i` are all one. Dropping either enable hides the request but keeps the flag.
- R8: A flag clears on `ack_i[g]`, or when a one is written to its bit at address 4. Other flags are left as they are. A change detected in the same cycle as a clear leaves the flag set.
- R9: `irq_any_o` is the OR of the requests. `irq_id_o` gives the lowest-numbered active request, so group 0 wins over 1 and 1 wins over 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 24 | Monitored pins, index 15 unused |
| gie_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data |
| ack_i | input | 3 | Per-group request acknowledge |
| irq_o | output | 3 | Per-group interrupt requests |
| irq_any_o | output | 1 | Any request active |
| irq_id_o | output | 2 | Index of highest-priority active request |

## Verification
The assertions check several rules on every cycle. A flag may rise only when its group enable was on in the cycle before. A flag may fall only after an acknowledge or a one written to its bit. A lone acknowledge does clear its flag. Group 0 always takes the encoded output when its request is active, and the pin 15 mask bit never reads back as one. Other behaviour needs the bench's scenarios, because it depends on a chain of inputs over several cycles. These are the three-edge delay from a pin change to its flag, changes in both directions, masked and absent pins being ignored, a change lost while its group was disabled, and a clear that meets a new change in the same cycle.

// File: rtl/pin_toggle_irq.sv
module pin_toggle_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] pin_i,
  input  logic        gie_i,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic [2:0]  rd_addr_i,
  output logic [7:0]  rd_data_o,
  input  logic [2:0]  ack_i,
  output logic [2:0]  irq_o,
  output logic        irq_any_o,
  output logic [1:0]  irq_id_o
);
  localparam logic [23:0] PIN_PRESENT = 24'hFF7FFF;
  localparam logic [2:0]  ADDR_EN     = 3'd3;
  localparam logic [2:0]  ADDR_FLAG   = 3'd4;

  logic [23:0] sync1, sync2, prev, mask;
  logic [2:0]  gen, flag, hit, clr;
  logic [23:0] tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign tog = (sync2 ^ prev) & mask;
  assign hit = gen & {|tog[23:16], |tog[14:8], |tog[7:0]};
  assign clr = ack_i | ((wr_en_i && wr_addr_i == ADDR_FLAG) ? wr_data_i[2:0] : 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      gen  <= '0;
      flag <= '0;
    end else begin
      for (int g = 0; g < 3; g++)
        if (wr_en_i && wr_addr_i == 3'(g))
          mask[g*8 +: 8] <= wr_data_i & PIN_PRESENT[g*8 +: 8];
      if (wr_en_i && wr_addr_i == ADDR_EN)
        gen <= wr_data_i[2:0];
      flag <= (flag & ~clr) | hit;
    end
  end

  always_comb begin
    case (rd_addr_i)
      3'd0:      rd_data_o = mask[7:0];
      3'd1:      rd_data_o = mask[15:8];
      3'd2:      rd_data_o = mask[23:16];
      ADDR_EN:   rd_data_o = {5'b0, gen};
      ADDR_FLAG: rd_data_o = {5'b0, flag};
      default:   rd_data_o = '0;
    endcase
  end

  assign irq_o     = flag & gen & {3{gie_i}};
  assign irq_any_o = |irq_o;
  assign irq_id_o  = irq_o[0] ? 2'd0 : irq_o[1] ? 2'd1 : irq_o[2] ? 2'd2 : 2'd0;
endmodule

module pin_toggle_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] gen,
  input logic [2:0] flag,
  input logic [2:0] hit,
  input logic [2:0] ack_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic [2:0] rd_addr_i,
  input logic [7:0] rd_data_o,
  input logic [2:0] irq_o,
  input logic       irq_any_o,
  input logic [1:0] irq_id_o
);
  for (genvar g = 0; g < 3; g++) begin : grp
    p_rise_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[g]) |-> $past(gen[g]));
    p_fall_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[g]) |-> $past(ack_i[g] || (wr_en_i && wr_addr_i == 3'd4 && wr_data_i[g])));
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[g] && !hit[g]) |=> !flag[g]);
  end

  p_group0_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[0] |-> (irq_id_o == 2'd0 && irq_any_o));
  p_no_pin15_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == 3'd1) |-> !rd_data_o[7]);
endmodule

bind pin_toggle_irq pin_toggle_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gen(gen), .flag(flag), .hit(hit), .ack_i(ack_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
  .irq_any_o(irq_any_o), .irq_id_o(irq_id_o)
);

// File: tb/pin_toggle_irq_test.sv
`timescale 1ns/1ps
module pin_toggle_irq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] pin_i = '0;
  logic        gie_i = 0;
  logic        wr_en_i = 0;
  logic [2:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o;
  logic [2:0]  ack_i = '0;
  logic [2:0]  irq_o;
  logic        irq_any_o;
  logic [1:0]  irq_id_o;

  pin_toggle_irq uut (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    logic [7:0] rd;
    logic [2:0] irq;
    logic [1:0] id;
    string      req;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (rd_data_o !== e.rd || irq_o !== e.irq || irq_id_o !== e.id || irq_any_o !== (|e.irq)) begin
        mismatched++;
        $display("FAIL %s: rd=%h irq=%b id=%0d any=%b, expected rd=%h irq=%b id=%0d any=%b",
                 e.req, rd_data_o, irq_o, irq_id_o, irq_any_o, e.rd, e.irq, e.id, |e.irq);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_state(input logic [2:0] a, input logic [7:0] rd,
                              input logic [2:0] irq, input logic [1:0] id, input string r);
    exp_t e;
    rd_addr_i = a;
    e.rd = rd; e.irq = irq; e.id = id; e.req = r;
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    step(1);
    wr_en_i = 0;
  endtask

  task automatic flip(input int idx);
    pin_i[idx] = ~pin_i[idx];
  endtask

  task automatic pulse_ack(input logic [2:0] a);
    ack_i = a;
    step(1);
    ack_i = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(1);
    // R1 reset state
    expect_state(3'd4, 8'h00, 3'b000, 2'd0, "R1 flags");
    expect_state(3'd0, 8'h00, 3'b000, 2'd0, "R1 mask0");
    expect_state(3'd3, 8'h00, 3'b000, 2'd0, "R1 enables");

    // R2 register map
    wr(3'd0, 8'h01);
    wr(3'd3, 8'h01);
    gie_i = 1;
    expect_state(3'd0, 8'h01, 3'b000, 2'd0, "R2 mask0 readback");
    expect_state(3'd3, 8'h01, 3'b000, 2'd0, "R2 enable readback");
    expect_state(3'd7, 8'h00, 3'b000, 2'd0, "R2 unused address");

    // R4 rising change, latency
    flip(0);
    step(2);
    expect_state(3'd4, 8'h00, 3'b000, 2'd0, "R4 not before third edge");
    step(1);
    expect_state(3'd4, 8'h01, 3'b001, 2'd0, "R4 rising sets flag");
    pulse_ack(3'b001);
    expect_state(3'd4, 8'h00, 3'b000, 2'd0, "R8 ack clears");

    // R5 unmasked pin
    flip(1);
    step(4);
    expect_state(3'd4, 8'h00, 3'b000, 2'd0, "R5 unmasked ignored");

    // R4 falling change
    flip(0);
    step(3);
    expect_state(3'd4, 8'h01, 3'b001, 2'd0, "R4 falling sets flag");
    pulse_ack(3'b001);

    // R6 disabled group loses change
    wr(3'd2, 8'hFF);
    flip(16);
    step(4);
    expect_state(3'd4, 8'h00, 3'b000, 2'd0, "R6 disabled group");
    wr(3'd3, 8'h05);
    step(2);
    expect_state(3'd4, 8'h00, 3'b000, 2'd0, "R6 no recovery");
    flip(16);
    step(3);
    expect_state(3'd4, 8'h04, 3'b100, 2'd2, "R9 group2 alone");

    // R7 gating
    gie_i = 0;
    expect_state(3'd4, 8'h04, 3'b000, 2'd0, "R7 global off");
    gie_i = 1;
    expect_state(3'd4, 8'h04, 3'b100, 2'd2, "R7 global on");
    wr(3'd3, 8'h01);
    expect_state(3'd4, 8'h04, 3'b000, 2'd0, "R7 group off keeps flag");
    wr(3'd3, 8'h07);

    // R3 absent pin 15
    wr(3'd1, 8'hFF);
    expect_state(3'd1, 8'h7F, 3'b100, 2'd2, "R3 mask bit reads zero");
    flip(15);
    step(4);
    expect_state(3'd4, 8'h04, 3'b100, 2'd2, "R3 pin15 ignored");

    // R9 priority
    flip(14);
    step(3);
    expect_state(3'd4, 8'h06, 3'b110, 2'd1, "R9 group1 over group2");
    flip(0);
    step(3);
    expect_state(3'd4, 8'h07, 3'b111, 2'd0, "R9 group0 first");

    // R8 write-one-to-clear
    wr(3'd4, 8'h02);
    expect_state(3'd4, 8'h05, 3'b101, 2'd0, "R8 w1c only group1");

    // R8 set beats same-cycle clear
    flip(0);
    step(2);
    pulse_ack(3'b001);
    expect_state(3'd4, 8'h05, 3'b101, 2'd0, "R8 set wins over ack");
    pulse_ack(3'b111);
    expect_state(3'd4, 8'h00, 3'b000, 2'd0, "R8 ack all");

    step(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule